// File: doc/BRIEF.md
# Sort test key generator

This block fills memory with test keys ahead of a sort. After a start pulse it emits a count of 32-bit keys. Sixteen keys go into each 512-bit word, and the words leave over a valid/ready handshake. A mode input picks the kind of sequence:

- a pseudo-random stream from a 32-bit xorshift generator,
- keys rising from 1,
- keys falling from the count down to 1.

The count and the seed are taken from the inputs at start. A done flag rises once the last word has been accepted. The memory writer downstream takes each word when both valid and ready are high.

Top module: `sort_keygen`

## Requirements
- R1: During and straight after reset, valid_o and done_o are low.
- R2: A start_i pulse while idle captures mode_i, count_i and seed_i. From the next cycle valid_o is high and done_o is low, as long as the count is nonzero.
- R3: Mode code 1 produces the keys 1, 2, ..., N in order.
- R4: Mode code 2 produces the keys N, N-1, ..., 1 in order.
- R5: Mode code 0 produces a pseudo-random stream. The state steps by x^=x<<13, then x^=x>>17, then x^=x<<5. The first key is one step from the seed, and each later key is one step from the key before it.
- R6: A seed of zero is replaced by 32'h9E3779B9 before the first step, so the state is never zero while running.
- R7: In each word, key k of that word (k = 0..15, counted in stream order) sits in bits [32k+31:32k], so the earliest key is in bits [31:0].
- R8: When N is not a multiple of 16, the unused slots of the final word hold 32'hFFFFFFFF. In mode 0 the generator still steps once for each padded slot.
- R9: While valid_o is high and ready_i is low, word_o and valid_o hold their values in the next cycle.
- R10: done_o rises in the cycle after the final word is accepted, with valid_o low. It stays high until the next start.
- R11: A start with a count of zero presents no word, and done_o is high in the next cycle.
- R12: A start_i pulse while words are still being emitted is ignored, and the stream in progress carries on unchanged.
- R13: Mode code 3 behaves like mode code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, acted on only while idle |
| mode_i | input | 2 | Pattern: 0 random, 1 ascending, 2 descending, 3 ascending |
| count_i | input | 32 | Number of keys N |
| seed_i | input | 32 | Random seed; zero is replaced |
| word_o | output | 512 | Sixteen packed keys |
| valid_o | output | 1 | Word is presented |
| ready_i | input | 1 | Downstream accepts the word |
| done_o | output | 1 | All words accepted |

## Verification
The stall-hold and done-timing assertions assume the handshake rules from the sink side: ready_i is sampled only at clock edges, and start_i is a single-cycle pulse. The bench drives every input on the falling edge, so each value is settled at the next rising edge. Stalls follow a fixed pattern of one low-ready cycle in three, which holds some words across several edges. A second start is injected in the middle of a stream to exercise the ignore path. Counts are kept small, and the chosen counts cover an exact multiple of sixteen, a partial last word, a single short word and zero.

// File: rtl/sort_keygen_pkg.sv
package sort_keygen_pkg;
  typedef enum logic [1:0] {
    MODE_RAND = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2,
    MODE_UP2  = 2'd3
  } mode_e;

  function automatic logic [31:0] xs_step(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/sort_keygen_lane.sv
module sort_keygen_lane
  import sort_keygen_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int CNT_W = 32
) (
  input  mode_e            mode_i,
  input  logic [CNT_W:0]   idx_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [31:0]      rand_i,
  output logic [31:0]      rand_o,
  output logic [KEY_W-1:0] key_o
);
  logic [CNT_W:0] n_ext;
  logic           pad;

  assign n_ext  = {1'b0, n_i};
  assign pad    = idx_i >= n_ext;
  assign rand_o = xs_step(rand_i);

  always_comb begin
    if (pad) begin
      key_o = '1;
    end else begin
      unique case (mode_i)
        MODE_RAND: key_o = KEY_W'(rand_o);
        MODE_DOWN: key_o = KEY_W'(n_ext - idx_i);
        default:   key_o = KEY_W'(idx_i + (CNT_W+1)'(1));
      endcase
    end
  end
endmodule

// File: rtl/sort_keygen_ctrl.sv
module sort_keygen_ctrl
  import sort_keygen_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          LANES    = 16,
  parameter logic [31:0] SEED_ALT = 32'h9E3779B9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [31:0]      seed_i,
  input  logic             ready_i,
  input  logic [31:0]      rand_next_i,
  output logic             busy_o,
  output logic             done_o,
  output mode_e            mode_o,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W:0]   base_o,
  output logic [31:0]      state_o
);
  localparam logic [CNT_W:0] STEP = (CNT_W+1)'(LANES);

  logic             busy_q, done_q;
  mode_e            mode_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W:0]   base_q;
  logic [31:0]      state_q;
  logic             go, acc, last;
  logic [CNT_W:0]   base_nx;

  assign go      = start_i && !busy_q;
  assign acc     = busy_q && ready_i;
  assign base_nx = base_q + STEP;
  assign last    = base_nx >= {1'b0, n_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= MODE_RAND;
      n_q     <= '0;
      base_q  <= '0;
      state_q <= SEED_ALT;
    end else if (go) begin
      mode_q  <= mode_i;
      n_q     <= count_i;
      base_q  <= '0;
      state_q <= (seed_i == '0) ? SEED_ALT : seed_i;
      busy_q  <= count_i != '0;
      done_q  <= count_i == '0;
    end else if (acc) begin
      base_q  <= base_nx;
      state_q <= rand_next_i;
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign mode_o  = mode_q;
  assign n_o     = n_q;
  assign base_o  = base_q;
  assign state_o = state_q;

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(acc || go)); // R10
  AST_SEED_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> state_q != '0); // R6
  AST_START_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> $stable(mode_q) && $stable(n_q)); // R12
endmodule

// File: rtl/sort_keygen.sv
module sort_keygen
  import sort_keygen_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int LANES = 16,
  parameter int CNT_W = 32,
  localparam int WORD_W = KEY_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [31:0]       seed_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              done_o
);
  mode_e            mode_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W:0]   base_q;
  logic [31:0]      state_q;
  logic             busy;
  logic [31:0]      chain [LANES+1];

  sort_keygen_ctrl #(.CNT_W(CNT_W), .LANES(LANES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_e'(mode_i)),
    .count_i     (count_i),
    .seed_i      (seed_i),
    .ready_i     (ready_i),
    .rand_next_i (chain[LANES]),
    .busy_o      (busy),
    .done_o      (done_o),
    .mode_o      (mode_q),
    .n_o         (n_q),
    .base_o      (base_q),
    .state_o     (state_q)
  );

  assign chain[0] = state_q;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    sort_keygen_lane #(.KEY_W(KEY_W), .CNT_W(CNT_W)) u_lane (
      .mode_i (mode_q),
      .idx_i  (base_q + (CNT_W+1)'(j)),
      .n_i    (n_q),
      .rand_i (chain[j]),
      .rand_o (chain[j+1]),
      .key_o  (word_o[j*KEY_W +: KEY_W])
    );
  end

  assign valid_o = busy;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(word_o)); // R9
  AST_DONE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o); // R10
endmodule

// File: tb/sort_keygen_test.sv
module sort_keygen_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [31:0]  count = '0;
  logic [31:0]  seed = '0;
  logic [511:0] word;
  logic         valid, ready = 1'b0, done;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sort_keygen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .count_i(count), .seed_i(seed), .word_o(word), .valid_o(valid),
    .ready_i(ready), .done_o(done)
  );

  function automatic logic [31:0] ref_xs(input logic [31:0] x);
    logic [31:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one stream: start, drain with optional stalls, check each word and done
  task automatic run_case(input string req, input logic [1:0] m, input int n,
                          input logic [31:0] sd, input bit stall, input bit poke);
    int idx = 0, cyc = 0;
    logic [31:0] rs;
    logic [511:0] prev_w = '0;
    bit prev_stall = 0;
    rs = (sd == 0) ? 32'h9E3779B9 : sd;
    @(negedge clk);
    start = 1'b1; mode = m; count = n; seed = sd; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    if (n > 0) check(valid && !done, "R2 start", {30'd0, valid, done}, 32'd2);
    while (idx < n && cyc < 4000) begin
      ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (poke && cyc == 2) begin
        start = 1'b1; mode = 2'd2; count = 32'd3; seed = 32'd7;
      end else start = 1'b0;
      #1;
      if (prev_stall)
        check(valid && word == prev_w, "R9 hold", word[31:0], prev_w[31:0]);
      if (valid && ready) begin
        logic [31:0] t, e;
        bit ok = 1;
        logic [31:0] a0 = 0, e0 = 0;
        t = rs;
        for (int j = 0; j < 16; j++) begin
          int i = idx + j;
          t = ref_xs(t);
          if (i >= n) e = 32'hFFFFFFFF;
          else if (m == 2'd0) e = t;
          else if (m == 2'd2) e = n - i;
          else e = i + 1;
          if (ok && word[j*32 +: 32] !== e) begin
            ok = 0; a0 = word[j*32 +: 32]; e0 = e;
          end
        end
        check(ok, req, a0, e0);
        rs = t;
        idx += 16;
      end
      prev_stall = valid && !ready;
      prev_w = word;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; ready = 1'b0;
    #1;
    check(done && !valid, (n == 0) ? "R11 empty" : "R10 done", {30'd0, done, valid}, 32'd2);
    @(negedge clk);
    check(done && !valid, "R10 done held", {30'd0, done, valid}, 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!valid && !done, "R1 reset", {30'd0, valid, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!valid && !done, "R1 after reset", {30'd0, valid, done}, 32'd0);
    run_case("R3 R7 ascending", 2'd1, 32, 32'd0, 1'b0, 1'b0);
    run_case("R4 R8 descending pad", 2'd2, 20, 32'd0, 1'b1, 1'b0);
    run_case("R5 R12 random poke", 2'd0, 40, 32'h12345678, 1'b1, 1'b1);
    run_case("R6 zero seed", 2'd0, 16, 32'd0, 1'b0, 1'b0);
    run_case("R11 empty", 2'd1, 0, 32'd5, 1'b0, 1'b0);
    run_case("R13 mode three", 2'd3, 5, 32'd0, 1'b1, 1'b0);
    run_case("R8 random pad", 2'd0, 3, 32'hDEADBEEF, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule